// File: doc/BRIEF.md
# Hierarchical Page Table Walker

This block translates a virtual page number into a physical page number by walking a forward-mapped, multi-level page table kept in memory. A walk request carries the virtual page number, a write flag, a mode select, the physical page of the root table and the physical page of a linear leaf region. The walker reads one table entry per step through a single request/response memory port. It returns either the physical page number or a page fault.

Top-down mode starts at the root table and descends one level per read. The most significant index field of the virtual page number selects the root entry. Bottom-up mode first reads the leaf entry for the page from a linearly laid-out leaf region. If that probe finds a resident page, the translation completes in a single read. If it does not, the walker restarts as a full top-down walk.

A successful translation writes the leaf entry back to the address it came from, with the referenced flag set. A write walk also sets the modified flag. Only one walk is in flight at a time, and a new walk is taken only after the previous result has been reported.

Top module: `pt_walker`

## Requirements
- R1: After reset, `walk_ready` is 1, and both `res_valid` and `req_valid` are 0.
- R2: A top-down walk makes exactly LEVELS reads, the first one in the root table. Each read address is table_page*2^OFF_W + index*4. Level k uses the index field at VPN bits [(LEVELS-k)*IDX_W-1 -: IDX_W], so level 0 is the most significant field.
- R3: Entry bit 0 is the valid flag. An intermediate entry with bit 0 clear ends the walk with `res_fault`=1, with no further reads and no write.
- R4: A leaf entry with bit 0 clear ends the walk with `res_fault`=1 and no write.
- R5: On success, `res_fault` is 0 and `res_ppn` equals leaf entry bits [12 +: PPN_W]. Exactly one write goes to the leaf entry's address. The written value is the read value with bit 1 (referenced) set and all other bits unchanged on a read walk.
- R6: On a successful write walk, the written-back leaf entry also has bit 2 (modified) set.
- R7: In bottom-up mode, the first read is at leaf_base_ppn*2^OFF_W + VPN*4. If that entry's bit 0 is set, the walk ends after that one read, returns its page number and writes the updated entry back to the same address.
- R8: In bottom-up mode, a probe entry with bit 0 clear is followed by a complete top-down walk from the root, for 1+LEVELS reads in total. Its result follows R2 to R6.
- R9: While `req_valid` is 1 and `req_ready` is 0, the request stays asserted, and its address, write flag and write data hold steady.
- R10: `res_valid` is a one-cycle pulse. It is high in the cycle right after the clock edge that takes the walk's last memory response or write acceptance. `walk_ready` is 0 from the cycle after a walk is accepted until that result has been reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| walk_valid | input | 1 | Walk request present |
| walk_ready | output | 1 | Walker idle, request taken when valid |
| walk_vpn | input | LEVELS*IDX_W | Virtual page number to translate |
| walk_write | input | 1 | Walk is for a store; set the modified flag |
| walk_bottom_up | input | 1 | Probe the linear leaf region first |
| root_ppn | input | PPN_W | Physical page of the root table |
| leaf_base_ppn | input | PPN_W | Physical page where the linear leaf region begins |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 1 | Page fault result |
| res_ppn | output | PPN_W | Translated physical page number (0 on fault) |
| req_valid | output | 1 | Memory request present |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | PPN_W+OFF_W | Byte address of the table entry |
| req_write | output | 1 | Request is a write-back |
| req_wdata | output | 32 | Entry value to write |
| resp_valid | input | 1 | Read data present |
| resp_data | input | 32 | Table entry read from memory |

## Verification
The memory request appears in the cycle after a walk is accepted and is held until `req_ready`. The result pulse is due in the cycle right after the edge that takes the last read response, or the write-back acceptance when there is one. The bench's memory model records the edge number of each such event when it drives or accepts it. The bench samples at falling edges and compares the edge on which `res_valid` is first seen with that recorded number, so a result one cycle early or late is caught. The model also counts reads and writes and captures the first read address, so the number of steps and the index order of every walk are checked along with its outcome.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ENT_W     = 32;
  localparam int V_BIT     = 0;
  localparam int REF_BIT   = 1;
  localparam int DIRTY_BIT = 2;
  localparam int PPN_LSB   = 12;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT,
    S_WBACK,
    S_DONE
  } walk_st_t;
endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
  parameter int LEVELS = 3,
  parameter int IDX_W  = 4,
  parameter int LVL_W  = 2
) (
  input  logic [LEVELS*IDX_W-1:0] vpn,
  input  logic [LVL_W-1:0]        lvl,
  output logic [IDX_W-1:0]        idx
);
  logic [IDX_W-1:0] fld [LEVELS];

  // level 0 takes the most significant field
  for (genvar g = 0; g < LEVELS; g++) begin : g_fld
    assign fld[g] = vpn[(LEVELS-g)*IDX_W-1 -: IDX_W];
  end

  always_comb begin
    idx = fld[0];
    for (int k = 1; k < LEVELS; k++) begin
      if (lvl == LVL_W'(k)) idx = fld[k];
    end
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int PPN_W  = 20,
  parameter int OFF_W  = 12,
  parameter int WORD_W = 4,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic [PPN_W-1:0]  base_ppn,
  input  logic [WORD_W-1:0] word_idx,
  output logic [PA_W-1:0]   addr
);
  // entries are four bytes wide
  assign addr = {base_ppn, {OFF_W{1'b0}}} + PA_W'({word_idx, 2'b00});
endmodule

// File: rtl/ptw_leaf_upd.sv
module ptw_leaf_upd
  import ptw_pkg::*;
#(
  parameter int PPN_W = 20
) (
  input  logic [ENT_W-1:0] entry,
  input  logic             is_write,
  output logic [ENT_W-1:0] upd,
  output logic [PPN_W-1:0] ppn
);
  always_comb begin
    upd            = entry;
    upd[REF_BIT]   = 1'b1;
    upd[DIRTY_BIT] = entry[DIRTY_BIT] | is_write;
  end
  assign ppn = entry[PPN_LSB +: PPN_W];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int IDX_W  = 4,
  parameter int PPN_W  = 20,
  parameter int OFF_W  = 12,
  localparam int VPN_W = LEVELS * IDX_W,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             walk_valid,
  output logic             walk_ready,
  input  logic [VPN_W-1:0] walk_vpn,
  input  logic             walk_write,
  input  logic             walk_bottom_up,
  input  logic [PPN_W-1:0] root_ppn,
  input  logic [PPN_W-1:0] leaf_base_ppn,
  output logic             res_valid,
  output logic             res_fault,
  output logic [PPN_W-1:0] res_ppn,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [PA_W-1:0]  req_addr,
  output logic             req_write,
  output logic [ENT_W-1:0] req_wdata,
  input  logic             resp_valid,
  input  logic [ENT_W-1:0] resp_data
);
  walk_st_t         st;
  logic [LVL_W-1:0] lvl_q;
  logic             probe_q;
  logic             wr_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0] root_q;
  logic [PA_W-1:0]  addr_q;
  logic [ENT_W-1:0] wdata_q;
  logic             res_valid_q;
  logic             res_fault_q;
  logic [PPN_W-1:0] res_ppn_q;

  // next table step selection
  logic [PPN_W-1:0] nb_base;
  logic [VPN_W-1:0] nb_vpn;
  logic [LVL_W-1:0] nb_lvl;
  logic [IDX_W-1:0] nb_idx;
  logic [PA_W-1:0]  tbl_addr;
  logic [PA_W-1:0]  lin_addr;
  logic [ENT_W-1:0] leaf_upd;
  logic [PPN_W-1:0] leaf_ppn;
  logic             is_leaf;
  logic             ent_ok;

  always_comb begin
    nb_base = root_ppn;
    nb_vpn  = walk_vpn;
    nb_lvl  = '0;
    if (st == S_WAIT) begin
      nb_vpn = vpn_q;
      if (probe_q) begin
        nb_base = root_q;
        nb_lvl  = '0;
      end else begin
        nb_base = resp_data[PPN_LSB +: PPN_W];
        nb_lvl  = LVL_W'(lvl_q + 1'b1);
      end
    end
  end

  ptw_index_sel #(.LEVELS(LEVELS), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_isel (
    .vpn(nb_vpn), .lvl(nb_lvl), .idx(nb_idx)
  );

  ptw_addr_gen #(.PPN_W(PPN_W), .OFF_W(OFF_W), .WORD_W(IDX_W)) u_tbl_addr (
    .base_ppn(nb_base), .word_idx(nb_idx), .addr(tbl_addr)
  );

  ptw_addr_gen #(.PPN_W(PPN_W), .OFF_W(OFF_W), .WORD_W(VPN_W)) u_lin_addr (
    .base_ppn(leaf_base_ppn), .word_idx(walk_vpn), .addr(lin_addr)
  );

  ptw_leaf_upd #(.PPN_W(PPN_W)) u_upd (
    .entry(resp_data), .is_write(wr_q), .upd(leaf_upd), .ppn(leaf_ppn)
  );

  assign is_leaf = probe_q || (lvl_q == LVL_W'(LEVELS - 1));
  assign ent_ok  = resp_data[V_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      lvl_q       <= '0;
      probe_q     <= 1'b0;
      wr_q        <= 1'b0;
      vpn_q       <= '0;
      root_q      <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      res_valid_q <= 1'b0;
      res_fault_q <= 1'b0;
      res_ppn_q   <= '0;
    end else begin
      res_valid_q <= 1'b0;
      case (st)
        S_IDLE: if (walk_valid) begin
          vpn_q   <= walk_vpn;
          wr_q    <= walk_write;
          root_q  <= root_ppn;
          lvl_q   <= '0;
          probe_q <= walk_bottom_up;
          addr_q  <= walk_bottom_up ? lin_addr : tbl_addr;
          st      <= S_ISSUE;
        end
        S_ISSUE: if (req_ready) st <= S_WAIT;
        S_WAIT: if (resp_valid) begin
          if (ent_ok && is_leaf) begin
            wdata_q     <= leaf_upd;
            res_ppn_q   <= leaf_ppn;
            res_fault_q <= 1'b0;
            st          <= S_WBACK;
          end else if (ent_ok || probe_q) begin
            // descend one level, or restart from the root after a failed probe
            probe_q <= 1'b0;
            lvl_q   <= nb_lvl;
            addr_q  <= tbl_addr;
            st      <= S_ISSUE;
          end else begin
            res_fault_q <= 1'b1;
            res_ppn_q   <= '0;
            res_valid_q <= 1'b1;
            st          <= S_DONE;
          end
        end
        S_WBACK: if (req_ready) begin
          res_valid_q <= 1'b1;
          st          <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign walk_ready = (st == S_IDLE);
  assign req_valid  = (st == S_ISSUE) || (st == S_WBACK);
  assign req_write  = (st == S_WBACK);
  assign req_addr   = addr_q;
  assign req_wdata  = wdata_q;
  assign res_valid  = res_valid_q;
  assign res_fault  = res_fault_q;
  assign res_ppn    = res_ppn_q;

  // R9: a stalled memory request keeps its contents
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                   && $stable(req_write) && $stable(req_wdata)));

  // R10: result lasts one cycle
  assert_res_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R10: no new walk taken while one is running
  assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (walk_valid && walk_ready) |=> !walk_ready);

  // R5: every write-back marks the entry resident and referenced
  assert_wb_ref_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |-> (req_wdata[REF_BIT] && req_wdata[V_BIT]));

  // R6: a store walk writes the modified flag
  assert_wb_dirty_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && wr_q) |-> req_wdata[DIRTY_BIT]);

  // R3: a fault result never follows a write-back
  assert_fault_nowb_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> !(res_valid && res_fault));
endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  localparam int LEVELS = 3;
  localparam int IDX_W  = 4;
  localparam int PPN_W  = 20;
  localparam int OFF_W  = 12;
  localparam int VPN_W  = LEVELS * IDX_W;
  localparam int PA_W   = PPN_W + OFF_W;
  localparam logic [PPN_W-1:0] ROOT = 20'h00100;
  localparam logic [PPN_W-1:0] LBASE = 20'h00800;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic walk_valid = 1'b0, walk_write = 1'b0, walk_bottom_up = 1'b0;
  logic [VPN_W-1:0] walk_vpn = '0;
  logic [PPN_W-1:0] root_ppn = ROOT, leaf_base_ppn = LBASE;
  logic walk_ready, res_valid, res_fault;
  logic [PPN_W-1:0] res_ppn;
  logic req_valid, req_write;
  logic req_ready = 1'b0;
  logic [PA_W-1:0] req_addr;
  logic [31:0] req_wdata;
  logic resp_valid = 1'b0;
  logic [31:0] resp_data = '0;

  pt_walker #(.LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) uut (
    .clk(clk), .rst(rst), .walk_valid(walk_valid), .walk_ready(walk_ready),
    .walk_vpn(walk_vpn), .walk_write(walk_write), .walk_bottom_up(walk_bottom_up),
    .root_ppn(root_ppn), .leaf_base_ppn(leaf_base_ppn), .res_valid(res_valid),
    .res_fault(res_fault), .res_ppn(res_ppn), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_data(resp_data)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [31:0] mem [int unsigned];
  int rd_cnt, wr_cnt, last_evt;
  int unsigned first_addr, rd_addr;
  bit rd_pend;
  int rd_dly;

  function automatic logic [31:0] rd(int unsigned a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory model: acts at falling edges on values stable since the rising edge
  initial begin
    rd_pend = 0; rd_dly = 0; rd_cnt = 0; wr_cnt = 0; last_evt = 0;
    forever begin
      @(negedge clk);
      resp_valid = 1'b0;
      if (rd_pend) begin
        if (rd_dly == 0) begin
          resp_valid = 1'b1;
          resp_data  = rd(rd_addr);
          rd_pend    = 0;
          last_evt   = cyc + 1;
        end else rd_dly--;
      end
      req_ready = ($urandom % 4) != 0;
      if (req_valid && req_ready) begin
        if (req_write) begin
          mem[req_addr] = req_wdata;
          wr_cnt++;
          last_evt = cyc + 1;
        end else begin
          if (rd_cnt == 0) first_addr = req_addr;
          rd_cnt++;
          rd_addr = req_addr;
          rd_pend = 1;
          rd_dly  = $urandom % 3;
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int unsigned ent_addr(logic [PPN_W-1:0] pg, int unsigned word);
    return (int'(pg) << OFF_W) + word * 4;
  endfunction

  function automatic logic [IDX_W-1:0] lvl_idx(logic [VPN_W-1:0] v, int l);
    return v[(LEVELS-l)*IDX_W-1 -: IDX_W];
  endfunction

  // lay out a table tree for one VPN; flt = level whose path entry is invalid
  task automatic build(logic [VPN_W-1:0] v, bit bu, int flt, bit probe_ok);
    logic [PPN_W-1:0] base = ROOT;
    mem.delete();
    for (int l = 0; l < LEVELS; l++) begin
      for (int i = 0; i < (1 << IDX_W); i++)
        mem[ent_addr(base, i)] = {20'h00400 + 20'($urandom % 256), 9'($urandom),
                                  2'($urandom), 1'($urandom)};
      if (l < LEVELS - 1) begin
        mem[ent_addr(base, lvl_idx(v, l))] = {20'h00300 + 20'(l), 11'h0, 1'(flt != l)};
        base = 20'h00300 + 20'(l);
      end else begin
        mem[ent_addr(base, lvl_idx(v, l))] = {20'($urandom), 9'($urandom),
                                              2'($urandom), 1'(flt != l)};
      end
    end
    if (bu) mem[ent_addr(LBASE, v)] = {20'($urandom), 9'($urandom), 2'($urandom), probe_ok};
  endtask

  // reference walk on the bench's own memory image
  task automatic model(input logic [VPN_W-1:0] v, input bit w, input bit bu,
                       output bit f, output logic [PPN_W-1:0] p, output int nrd,
                       output int unsigned a0, output int unsigned wa,
                       output logic [31:0] wd, output string tag);
    logic [31:0] e;
    logic [PPN_W-1:0] base = ROOT;
    bit hit = 0;
    int unsigned a;
    nrd = 0; f = 0; p = '0; wa = 0; wd = '0;
    tag = w ? "R6" : "R5";
    if (bu) begin
      a = ent_addr(LBASE, v); a0 = a; nrd++;
      e = rd(a);
      if (e[0]) begin hit = 1; wa = a; tag = "R7"; end
      else tag = "R8";
    end
    if (!hit) begin
      for (int l = 0; l < LEVELS; l++) begin
        a = ent_addr(base, lvl_idx(v, l));
        if (nrd == 0) a0 = a;
        nrd++;
        e = rd(a);
        if (!e[0]) begin
          f = 1;
          if (!bu) tag = (l == LEVELS - 1) ? "R4" : "R3";
          break;
        end
        if (l == LEVELS - 1) wa = a;
        else base = e[31:12];
      end
    end
    if (!f) begin
      p = e[31:12];
      wd = e | 32'h2 | (w ? 32'h4 : 32'h0);
    end
  endtask

  task automatic run_walk(logic [VPN_W-1:0] v, bit w, bit bu);
    bit ef; logic [PPN_W-1:0] ep; int enrd; int unsigned ea0, ewa;
    logic [31:0] ewd; string tag; int n = 0;
    model(v, w, bu, ef, ep, enrd, ea0, ewa, ewd, tag);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    chk(walk_ready == 1'b1, "R10 ready when idle", walk_ready, 1);
    walk_valid = 1'b1; walk_vpn = v; walk_write = w; walk_bottom_up = bu;
    @(negedge clk);
    walk_valid = 1'b0;
    chk(walk_ready == 1'b0, "R10 busy after accept", walk_ready, 0);
    while (!res_valid && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(res_valid == 1'b1, "R10 result arrives", res_valid, 1);
    chk(cyc == last_evt, "R10 result timing", cyc, last_evt);
    chk(res_fault == ef, {tag, " fault flag"}, res_fault, ef);
    chk(res_ppn == ep, {tag, " ppn"}, res_ppn, ep);
    chk(rd_cnt == enrd, {tag, " read count (R2)"}, rd_cnt, enrd);
    chk(first_addr == ea0, {tag, " first read address (R2)"}, first_addr, ea0);
    chk(wr_cnt == (ef ? 0 : 1), {tag, " write count"}, wr_cnt, ef ? 0 : 1);
    if (!ef) chk(rd(ewa) == ewd, {tag, " written-back entry"}, rd(ewa), ewd);
    @(negedge clk);
    chk(res_valid == 1'b0, "R10 pulse one cycle", res_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd4321));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(walk_ready == 1'b1, "R1 walk_ready", walk_ready, 1);
    chk(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
    chk(req_valid == 1'b0, "R1 req_valid", req_valid, 0);

    // R2 R5: plain top-down read walk
    build(12'h5A3, 0, -1, 0); run_walk(12'h5A3, 0, 0);
    // R6: store walk, all-ones VPN
    build(12'hFFF, 0, -1, 0); run_walk(12'hFFF, 1, 0);
    // R3: invalid root entry, then invalid middle entry
    build(12'h31C, 0, 0, 0); run_walk(12'h31C, 0, 0);
    build(12'h31C, 0, 1, 0); run_walk(12'h31C, 1, 0);
    // R4: invalid leaf
    build(12'h000, 0, 2, 0); run_walk(12'h000, 1, 0);
    // R7: resident probe, read and store
    build(12'h6E1, 1, -1, 1); run_walk(12'h6E1, 0, 1);
    build(12'hFFF, 1, -1, 1); run_walk(12'hFFF, 1, 1);
    // R8: failed probe falls back to the full walk, then a fallback that faults
    build(12'h2B7, 1, -1, 0); run_walk(12'h2B7, 1, 1);
    build(12'h000, 1, 2, 0); run_walk(12'h000, 0, 1);

    for (int t = 0; t < 40; t++) begin
      logic [VPN_W-1:0] v = VPN_W'($urandom);
      bit bu = 1'($urandom);
      int f = $urandom % 6;
      build(v, bu, (f < LEVELS) ? f : -1, 1'($urandom));
      run_walk(v, 1'($urandom), bu);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog expired act=%0d exp=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule